// File: doc/BRIEF.md
# Slave-Break Line-Quiet Detector and Break Driver

This block lets a slave device on a shared single-wire data bus claim the master's attention. It samples the synchronized level of the idle data line on every occurrence of a periodic time-base tick (2000 ticks per second, so 0.5 ms each). It first qualifies a run of low samples, then a run of high samples. Only after both phases does it pull the data line low itself for a fixed number of ticks. That timed pull-down is the slave break. It then releases the line and starts watching again.

The host logic raises a break request whenever it wants the master's attention. If the quiet pattern completes while no request is pending, the block parks in a ready state. It drives the break as soon as a request appears, without waiting for another tick. The transceiver reports every completed received byte with a one-cycle activity strobe. The strobe returns the detector to the start of the low phase from any state, and an active break is abandoned without a completion pulse. The output is an enable for an external open-drain pull-down.

Top module: `slv_brk_gen`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, pull_o and done_o are 0.
- R2: Phase 1 completes after LOW_TICKS (default 10) consecutive tick cycles with line_i = 0. A tick cycle with line_i = 1 during phase 1 empties the run.
- R3: After phase 1, phase 2 completes after HIGH_TICKS (default 4) consecutive tick cycles with line_i = 1. If req_i = 1 in the cycle of the last of these ticks, pull_o is 1 from the following clock edge.
- R4: A tick cycle with line_i = 0 during phase 2 returns the block to phase 1 with an empty run. That low sample is not counted toward the new run.
- R5: Once asserted, pull_o stays 1 for exactly HOLD_TICKS (default 10) tick cycles and falls at the edge that ends the last of them. line_i is ignored while the break is held.
- R6: If req_i = 0 at the end of phase 2, the block waits with pull_o = 0. A later cycle with req_i = 1, tick or not, asserts pull_o from the next edge.
- R7: done_o is a one-cycle pulse, asserted in the same cycle that pull_o falls at the end of a completed hold.
- R8: A cycle with activity_i = 1 returns the block to the empty phase 1 from any state: pull_o and done_o are 0 from the next edge, and a pending ready state is lost.
- R9: When activity_i = 1 coincides with the final hold tick, activity wins. pull_o falls but done_o stays 0.
- R10: Cycles with tick_i = 0 never advance, clear or change the detector, whatever line_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle time-base strobe, every 0.5 ms |
| line_i | input | 1 | Synchronized data-line level (1 = released/high) |
| req_i | input | 1 | Break request from host logic |
| activity_i | input | 1 | One-cycle strobe per completed received byte |
| pull_o | output | 1 | Open-drain pull-down enable for the data line |
| done_o | output | 1 | One-cycle pulse when a completed break is released |

## Verification
Two events can land on the same clock edge: the tick that ends a break hold, and the activity strobe that aborts it. The bench provokes the clash by driving the tenth hold tick together with activity_i. It then requires pull_o to fall with done_o held at 0 on that edge and the next. A similar overlap is forced between a ready state and activity in one cycle followed by a request, and the request must then produce no break. Both outcomes are judged at the ports against expected pull and done values queued by the driver.

// File: rtl/slv_brk_pkg.sv
package slv_brk_pkg;
  typedef enum logic [1:0] {
    PH_LOW  = 2'd0,
    PH_HIGH = 2'd1,
    PH_RDY  = 2'd2,
    PH_BRK  = 2'd3
  } phase_e;
endpackage

// File: rtl/slv_brk_cnt.sv
module slv_brk_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= '0;
    else if (clr_i) val_o <= '0;
    else if (inc_i) val_o <= val_o + 1'b1;
  end
endmodule

// File: rtl/slv_brk_fsm.sv
module slv_brk_fsm
  import slv_brk_pkg::*;
#(
  parameter int LOW_TICKS  = 10,
  parameter int HIGH_TICKS = 4,
  parameter int HOLD_TICKS = 10,
  parameter int CW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic          req_i,
  input  logic          activity_i,
  input  logic [CW-1:0] cnt_i,
  output logic          clr_o,
  output logic          inc_o,
  output logic          pull_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LowLast  = CW'(LOW_TICKS - 1);
  localparam logic [CW-1:0] HighLast = CW'(HIGH_TICKS - 1);
  localparam logic [CW-1:0] HoldLast = CW'(HOLD_TICKS - 1);

  phase_e st_q, st_d;
  logic   done_d;

  always_comb begin
    st_d   = st_q;
    clr_o  = 1'b0;
    inc_o  = 1'b0;
    done_d = 1'b0;
    if (activity_i) begin
      st_d  = PH_LOW;
      clr_o = 1'b1;
    end else begin
      unique case (st_q)
        PH_LOW: if (tick_i) begin
          if (line_i) clr_o = 1'b1;
          else if (cnt_i == LowLast) begin
            st_d  = PH_HIGH;
            clr_o = 1'b1;
          end else inc_o = 1'b1;
        end
        PH_HIGH: if (tick_i) begin
          if (!line_i) begin
            st_d  = PH_LOW;
            clr_o = 1'b1;
          end else if (cnt_i == HighLast) begin
            st_d  = req_i ? PH_BRK : PH_RDY;
            clr_o = 1'b1;
          end else inc_o = 1'b1;
        end
        PH_RDY: if (req_i) begin
          st_d  = PH_BRK;
          clr_o = 1'b1;
        end
        PH_BRK: if (tick_i) begin
          // own pull makes line_i meaningless here
          if (cnt_i == HoldLast) begin
            st_d   = PH_LOW;
            clr_o  = 1'b1;
            done_d = 1'b1;
          end else inc_o = 1'b1;
        end
        default: st_d = PH_LOW;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_LOW;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
    end
  end

  assign pull_o = (st_q == PH_BRK);
endmodule

// File: rtl/slv_brk_gen.sv
module slv_brk_gen #(
  parameter int LOW_TICKS  = 10,
  parameter int HIGH_TICKS = 4,
  parameter int HOLD_TICKS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic req_i,
  input  logic activity_i,
  output logic pull_o,
  output logic done_o
);
  localparam int MaxLH   = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
  localparam int MaxTick = (MaxLH > HOLD_TICKS) ? MaxLH : HOLD_TICKS;
  localparam int CW      = (MaxTick > 2) ? $clog2(MaxTick) : 1;

  logic [CW-1:0] cnt;
  logic          clr, inc;

  slv_brk_cnt #(.CW(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (inc),
    .val_o (cnt)
  );

  slv_brk_fsm #(
    .LOW_TICKS (LOW_TICKS),
    .HIGH_TICKS(HIGH_TICKS),
    .HOLD_TICKS(HOLD_TICKS),
    .CW        (CW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line_i),
    .req_i     (req_i),
    .activity_i(activity_i),
    .cnt_i     (cnt),
    .clr_o     (clr),
    .inc_o     (inc),
    .pull_o    (pull_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/slv_brk_chk.sv
module slv_brk_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic req_i,
  input logic activity_i,
  input logic pull_o,
  input logic done_o
);
  // R7
  done_at_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!pull_o && $past(pull_o)));

  // R5
  release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_o) |-> $past(tick_i || activity_i));

  // R8
  activity_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    activity_i |=> (!pull_o && !done_o));

  // R3
  pull_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_o) |-> $past(req_i));

  // R10
  quiet_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !activity_i && !req_i) |=> $stable(pull_o));
endmodule

bind slv_brk_gen slv_brk_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .req_i     (req_i),
  .activity_i(activity_i),
  .pull_o    (pull_o),
  .done_o    (done_o)
);

// File: tb/slv_brk_gen_tb_top.sv
module slv_brk_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0, line_i = 1'b1, req_i = 1'b0, activity_i = 1'b0;
  logic pull_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  p;
    logic  d;
    string rid;
  } exp_t;
  exp_t q[$];

  always #4 clk_i = ~clk_i;

  slv_brk_gen dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .line_i    (line_i),
    .req_i     (req_i),
    .activity_i(activity_i),
    .pull_o    (pull_o),
    .done_o    (done_o)
  );

  // monitor: compare one queued item per edge
  always @(posedge clk_i) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (pull_o !== e.p || done_o !== e.d) begin
        n_fail++;
        $display("FAIL %s: pull/done actual %b%b expected %b%b at %0t",
                 e.rid, pull_o, done_o, e.p, e.d, $time);
      end
    end
  end

  task automatic cyc(input logic tk, input logic ln, input logic rq, input logic ac,
                     input logic ep, input logic ed, input string rid);
    exp_t e;
    @(negedge clk_i);
    tick_i = tk; line_i = ln; req_i = rq; activity_i = ac;
    e.p = ep; e.d = ed; e.rid = rid;
    q.push_back(e);
  endtask

  task automatic tk(input logic ln, input logic rq, input logic ep, input logic ed,
                    input string rid);
    cyc(1'b1, ln, rq, 1'b0, ep, ed, rid);
    cyc(1'b0, ln, rq, 1'b0, ep, 1'b0, rid);
  endtask

  task automatic run(input int n, input logic ln, input logic rq, input logic ep,
                     input string rid);
    for (int i = 0; i < n; i++) tk(ln, rq, ep, 1'b0, rid);
  endtask

  task automatic to_break(input string rid);
    run(10, 1'b0, 1'b0, 1'b0, "R2");
    run(3, 1'b1, 1'b1, 1'b0, "R3");
    tk(1'b1, 1'b1, 1'b1, 1'b0, rid);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (pull_o !== 1'b0 || done_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: pull/done actual %b%b expected 00", pull_o, done_o);
    end
    rst_ni = 1'b1;
    cyc(0, 1, 0, 0, 0, 0, "R1");

    // full break with line high during hold (R2 R3 R5 R7)
    to_break("R3");
    run(9, 1'b1, 1'b0, 1'b1, "R5");
    tk(1'b0, 1'b0, 1'b0, 1'b1, "R7");

    // high tick empties phase-1 run (R2)
    run(9, 1'b0, 1'b0, 1'b0, "R2");
    tk(1'b1, 1'b0, 1'b0, 1'b0, "R2");
    run(9, 1'b0, 1'b0, 1'b0, "R2");
    run(4, 1'b1, 1'b1, 1'b0, "R2");

    // low in phase 2 restarts, not counted (R4)
    run(10, 1'b0, 1'b0, 1'b0, "R4");
    run(2, 1'b1, 1'b1, 1'b0, "R4");
    tk(1'b0, 1'b1, 1'b0, 1'b0, "R4");
    run(9, 1'b0, 1'b0, 1'b0, "R4");
    run(4, 1'b1, 1'b1, 1'b0, "R4");

    // ready wait, request without tick (R6)
    run(10, 1'b0, 1'b0, 1'b0, "R6");
    run(4, 1'b1, 1'b0, 1'b0, "R6");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0, "R6");
    cyc(0, 0, 1, 0, 1, 0, "R6");
    run(9, 1'b0, 1'b0, 1'b1, "R5");
    tk(1'b0, 1'b0, 1'b0, 1'b1, "R7");

    // activity aborts break and restarts phase 1 (R8)
    to_break("R3");
    run(3, 1'b0, 1'b0, 1'b1, "R5");
    cyc(0, 0, 0, 1, 0, 0, "R8");
    run(4, 1'b1, 1'b1, 1'b0, "R8");

    // activity coincides with final hold tick (R9)
    to_break("R3");
    run(9, 1'b0, 1'b0, 1'b1, "R5");
    cyc(1, 0, 0, 1, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, 0, "R9");

    // activity in ready state drops it (R8)
    run(10, 1'b0, 1'b0, 1'b0, "R8");
    run(4, 1'b1, 1'b0, 1'b0, "R8");
    cyc(0, 0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0, "R8");

    // activity in phase 2 (R8)
    run(10, 1'b0, 1'b0, 1'b0, "R8");
    run(2, 1'b1, 1'b0, 1'b0, "R8");
    cyc(0, 1, 0, 1, 0, 0, "R8");
    run(2, 1'b1, 1'b1, 1'b0, "R8");

    // non-tick cycles with line high do not disturb the run (R10)
    run(5, 1'b0, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 0, 0, "R10");
    run(5, 1'b0, 1'b0, 1'b0, "R10");
    run(3, 1'b1, 1'b1, 1'b0, "R10");
    tk(1'b1, 1'b1, 1'b1, 1'b0, "R10");
    run(9, 1'b0, 1'b0, 1'b1, "R5");
    tk(1'b0, 1'b0, 1'b0, 1'b1, "R7");

    cyc(0, 1, 0, 0, 0, 0, "R10");
    @(negedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule